// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block decides when a clock-distribution buffer may turn on its differential outputs. It runs from a free-running local timing clock. It watches four things: a supply-good flag, an active-low power-down request, a divided copy of the reference clock (`ref_tick`) and a PLL-lock flag. It moves through four states: power off, supply settling, waiting, and normal operation. The outputs are enabled only in normal operation.

After the supply comes up, the block waits a fixed number of timing cycles for it to settle. It then waits until three conditions hold together: the reference clock is toggling, power-down is released and the PLL reports lock. A power-down request or loss of the reference clock sends the block back to waiting. Loss of supply sends it back to power off from any state.

A separate configuration bit asks the buffer to park its outputs high while it waits with power-down released. The parking delay is a cycle count, sized so that the outputs are driven high within the allowed time after release.

With the default timing clock of 1 MHz, the worst-case path to enabled outputs is the settling delay plus a few synchronizer cycles. That is about 265 µs, well below 1 ms. The park delay of 20 cycles plus 3 cycles of pipeline is far below 300 µs.

Top module: `clkbuf_pwrseq`

## Requirements
- R1: During and after a synchronous reset, `seq_state` is 0, `out_en` is 0 and `out_park_hi` is 0.
- R2: The state encoding is 0 = power off, 1 = settling, 2 = waiting, 3 = normal. With `supply_ok` high, the block leaves state 0 for state 1 on the third clock edge after the input rises, because of the two-flop synchronizer.
- R3: The block stays in state 1 for exactly SETTLE_CYC cycles. It then moves to state 2.
- R4: When the synchronized supply flag is low, the block enters state 0 at the next edge from any state. A settle interrupted this way restarts with a full SETTLE_CYC count.
- R5: The reference clock is counted valid once EDGE_MIN rising edges of the synchronized `ref_tick` have arrived, each within TIMEOUT cycles of the one before. It becomes invalid after TIMEOUT cycles with no rising edge. Edges spaced wider than TIMEOUT never make it valid.
- R6: State 2 moves to state 3 only when clock-valid, power-down released and lock (all synchronized) hold together. When they do, it moves at the next edge.
- R7: `out_en` is a register that is 1 exactly when `seq_state` is 3. It has no combinational path from any input.
- R8: From state 3, asserting power-down or losing the reference clock returns the block to state 2 with `out_en` low.
- R9: With supply valid and power-down released but no reference edges, the block stays in state 2 with `out_en` low indefinitely.
- R10: With `cfg_park_hi` = 1, in state 2 with power-down released, `out_park_hi` rises PARK_DLY+3 edges after `pwr_down_n` rises. It is 0 outside state 2 and while power-down is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above rise threshold (asynchronous) |
| pwr_down_n | input | 1 | Active-low power-down request (asynchronous) |
| ref_tick | input | 1 | Divided copy of the reference clock (asynchronous) |
| pll_lock | input | 1 | PLL locked to reference (asynchronous) |
| cfg_park_hi | input | 1 | Park outputs high while waiting after power-down release |
| out_en | output | 1 | Differential output enable |
| out_park_hi | output | 1 | Drive outputs to a static high level |
| seq_state | output | 2 | Current state, encoded as in R2 |

## Verification
The assertions take `ref_tick` to be a divided reference clock. Each of its levels must be held for at least two timing cycles, so that every rising edge survives the synchronizer, and the bench's toggle generator never holds a level for fewer than three cycles. `cfg_park_hi` is treated as a quasi-static setting. The bench changes it only while the block sits in the waiting state, away from any transition into normal operation. The asynchronous inputs are driven on the falling clock edge, so the synchronizers never see a change at the sampling edge. The latency checks can then count edges exactly.

// File: rtl/clkbuf_pwrseq_pkg.sv
// Shared state encoding for the clock buffer power-up sequencer.
// Assumes nothing beyond a 2-bit state field visible at the top ports.
package clkbuf_pwrseq_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_WAIT   = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/clkbuf_sync2.sv
// Two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a level or slow toggle, not a multi-bit bus value.
module clkbuf_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture then re-register each bit in the timing domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/clkbuf_ref_mon.sv
// Reference activity detector: counts rising edges of a synchronized
// divided reference. Valid after EDGE_MIN edges with no gap of TIMEOUT
// cycles. Invalid after a TIMEOUT-cycle gap.
// Assumes ref_s holds each level for at least two timing cycles.
module clkbuf_ref_mon #(
    parameter int EDGE_MIN = 4,
    parameter int TIMEOUT  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_s,
    output logic clk_ok
);
    localparam int GW = $clog2(TIMEOUT + 1);
    localparam int EW = $clog2(EDGE_MIN + 1);
    localparam logic [GW-1:0] GAP_MAX  = GW'(TIMEOUT);
    localparam logic [GW-1:0] GAP_LAST = GW'(TIMEOUT - 1);
    localparam logic [EW-1:0] EDGE_TOP = EW'(EDGE_MIN);

    logic          ref_d;
    logic [GW-1:0] gap;
    logic [EW-1:0] ecnt;
    logic          rise;
    logic          stale;

    assign rise   = ref_s & ~ref_d;
    assign stale  = ~rise & (gap == GAP_LAST);
    assign clk_ok = (ecnt == EDGE_TOP);

    // Track gap since last rising edge and count qualifying edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_d <= 1'b0;
            gap   <= GAP_MAX;
            ecnt  <= '0;
        end else begin
            ref_d <= ref_s;
            if (rise)
                gap <= '0;
            else if (gap != GAP_MAX)
                gap <= gap + 1'b1;
            if (stale)
                ecnt <= '0;
            else if (rise && ecnt != EDGE_TOP)
                ecnt <= ecnt + 1'b1;
        end
    end
endmodule

// File: rtl/clkbuf_seq_fsm.sv
// Power-up state machine with settle timer and park-high delay.
// Assumes all condition inputs are already in the timing clock domain.
module clkbuf_seq_fsm
    import clkbuf_pwrseq_pkg::*;
#(
    parameter int SETTLE_CYC = 260,
    parameter int PARK_DLY   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_s,
    input  logic       pd_rel_s,
    input  logic       lock_s,
    input  logic       clk_ok,
    input  logic       cfg_park,
    output seq_state_e state,
    output logic       out_en,
    output logic       out_park_hi
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int PW = $clog2(PARK_DLY + 1);
    localparam logic [SW-1:0] SET_LAST = SW'(SETTLE_CYC - 1);
    localparam logic [PW-1:0] PARK_TOP = PW'(PARK_DLY);

    seq_state_e    nstate;
    logic [SW-1:0] scnt;
    logic [PW-1:0] pcnt;
    logic          waiting_rel;

    assign waiting_rel = (state == ST_WAIT) && pd_rel_s;

    // Next-state selection; supply loss wins over every other condition.
    always_comb begin
        nstate = state;
        if (!sup_s) begin
            nstate = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:    nstate = ST_SETTLE;
                ST_SETTLE: if (scnt == SET_LAST) nstate = ST_WAIT;
                ST_WAIT:   if (clk_ok && pd_rel_s && lock_s) nstate = ST_RUN;
                ST_RUN:    if (!clk_ok || !pd_rel_s) nstate = ST_WAIT;
                default:   nstate = ST_OFF;
            endcase
        end
    end

    // State, settle counter and registered output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            scnt   <= '0;
            out_en <= 1'b0;
        end else begin
            state  <= nstate;
            scnt   <= (state == ST_SETTLE && nstate == ST_SETTLE) ? scnt + 1'b1 : '0;
            out_en <= (nstate == ST_RUN);
        end
    end

    // Park-high delay counter and registered park output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt        <= '0;
            out_park_hi <= 1'b0;
        end else begin
            out_park_hi <= cfg_park && waiting_rel && (pcnt == PARK_TOP);
            if (!waiting_rel)
                pcnt <= '0;
            else if (pcnt != PARK_TOP)
                pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/clkbuf_pwrseq.sv
// Top of the clock buffer power-up sequencer. It synchronizes the
// asynchronous controls, detects reference activity and runs the state
// machine.
// Assumes ref_tick is a divided reference, slower than half of clk.
module clkbuf_pwrseq
    import clkbuf_pwrseq_pkg::*;
#(
    parameter int SETTLE_CYC = 260,
    parameter int PARK_DLY   = 20,
    parameter int EDGE_MIN   = 4,
    parameter int TIMEOUT    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pwr_down_n,
    input  logic       ref_tick,
    input  logic       pll_lock,
    input  logic       cfg_park_hi,
    output logic       out_en,
    output logic       out_park_hi,
    output logic [1:0] seq_state
);
    logic [3:0] raw_vec;
    logic [3:0] syn_vec;
    logic       sup_s;
    logic       pd_rel_s;
    logic       lock_s;
    logic       ref_s;
    logic       clk_ok;
    seq_state_e state;

    assign raw_vec   = {ref_tick, pll_lock, pwr_down_n, supply_ok};
    assign sup_s     = syn_vec[0];
    assign pd_rel_s  = syn_vec[1];
    assign lock_s    = syn_vec[2];
    assign ref_s     = syn_vec[3];
    assign seq_state = state;

    clkbuf_sync2 #(.W(4)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_vec),
        .q     (syn_vec)
    );

    clkbuf_ref_mon #(.EDGE_MIN(EDGE_MIN), .TIMEOUT(TIMEOUT)) u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_s  (ref_s),
        .clk_ok (clk_ok)
    );

    clkbuf_seq_fsm #(.SETTLE_CYC(SETTLE_CYC), .PARK_DLY(PARK_DLY)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sup_s       (sup_s),
        .pd_rel_s    (pd_rel_s),
        .lock_s      (lock_s),
        .clk_ok      (clk_ok),
        .cfg_park    (cfg_park_hi),
        .state       (state),
        .out_en      (out_en),
        .out_park_hi (out_park_hi)
    );
endmodule

// File: rtl/clkbuf_pwrseq_chk.sv
// Property checker for the sequencer, bound to the top module.
// Assumes the synchronized condition signals of the top are visible.
module clkbuf_pwrseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_s,
    input logic       pd_rel_s,
    input logic       lock_s,
    input logic       clk_ok,
    input logic       cfg_park_hi,
    input logic [1:0] seq_state,
    input logic       out_en,
    input logic       out_park_hi
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (seq_state == 2'd0 && !out_en && !out_park_hi));

    a_r2_off_exit: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == 2'd0 |=> (seq_state == 2'd0 || seq_state == 2'd1));

    a_r3_settle_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == 2'd1 |=> seq_state != 2'd3);

    a_r4_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> seq_state == 2'd0);

    a_r6_gated_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd2 && !(clk_ok && pd_rel_s && lock_s)) |=> seq_state != 2'd3);

    a_r6_prompt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd2 && sup_s && clk_ok && pd_rel_s && lock_s) |=> seq_state == 2'd3);

    a_r7_en_tracks_run: assert property (@(posedge clk) disable iff (!rst_n)
        out_en == (seq_state == 2'd3));

    a_r8_run_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd3 && sup_s && (!pd_rel_s || !clk_ok)) |=> (seq_state == 2'd2 && !out_en));

    a_r10_park_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        out_park_hi |-> ($past(cfg_park_hi) && $past(seq_state) == 2'd2 && $past(pd_rel_s)));
endmodule

bind clkbuf_pwrseq clkbuf_pwrseq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sup_s       (sup_s),
    .pd_rel_s    (pd_rel_s),
    .lock_s      (lock_s),
    .clk_ok      (clk_ok),
    .cfg_park_hi (cfg_park_hi),
    .seq_state   (seq_state),
    .out_en      (out_en),
    .out_park_hi (out_park_hi)
);

// File: tb/clkbuf_pwrseq_tb.sv
// Bench: behavioural reference model updated on every rising edge and
// compared on every falling edge, plus directed checks per requirement.
module clkbuf_pwrseq_tb;
    localparam int CLK_NS = 10;
    localparam int SC   = 260;
    localparam int PD   = 20;
    localparam int EMIN = 4;
    localparam int TO   = 16;
    localparam int WD   = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, pwr_down_n = 1'b0, ref_tick = 1'b0, pll_lock = 1'b0, cfg_park_hi = 1'b0;
    logic out_en, out_park_hi;
    logic [1:0] seq_state;

    int n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit cmp_on = 1'b0;
    bit ref_run = 1'b0;
    int ref_half = 3;
    int rc = 0;

    // Model state
    int m_st, m_sc, m_pc, m_gap, m_ecnt;
    bit m_en, m_park, m_rd;
    bit sp[2], pp[2], lp[2], rp[2];

    always #(CLK_NS/2) clk = ~clk;

    clkbuf_pwrseq #(.SETTLE_CYC(SC), .PARK_DLY(PD), .EDGE_MIN(EMIN), .TIMEOUT(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pwr_down_n(pwr_down_n),
        .ref_tick(ref_tick), .pll_lock(pll_lock), .cfg_park_hi(cfg_park_hi),
        .out_en(out_en), .out_park_hi(out_park_hi), .seq_state(seq_state)
    );

    // Divided reference generator
    always @(negedge clk) begin
        if (ref_run) begin
            if (rc >= ref_half - 1) begin
                ref_tick = ~ref_tick;
                rc = 0;
            end else begin
                rc = rc + 1;
            end
        end
    end

    // Reference model, from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_sc = 0; m_pc = 0; m_gap = TO; m_ecnt = 0;
            m_en = 0; m_park = 0; m_rd = 0;
            sp = '{0, 0}; pp = '{0, 0}; lp = '{0, 0}; rp = '{0, 0};
        end else begin
            bit sup, pdr, lk, rise, ok, stale, pk;
            sup = sp[1]; pdr = pp[1]; lk = lp[1];
            rise  = rp[1] && !m_rd;
            ok    = (m_ecnt == EMIN);
            stale = !rise && (m_gap == TO - 1);
            if (rise) m_gap = 0; else if (m_gap != TO) m_gap++;
            if (stale) m_ecnt = 0; else if (rise && m_ecnt != EMIN) m_ecnt++;
            m_rd = rp[1];
            pk = cfg_park_hi && m_st == 2 && pdr && m_pc == PD;
            if (m_st == 2 && pdr) m_pc = (m_pc == PD) ? PD : m_pc + 1; else m_pc = 0;
            if (!sup) begin
                m_st = 0; m_sc = 0;
            end else begin
                case (m_st)
                    0: begin m_st = 1; m_sc = 0; end
                    1: if (m_sc == SC - 1) begin m_st = 2; m_sc = 0; end else m_sc++;
                    2: if (ok && pdr && lk) m_st = 3;
                    default: if (!ok || !pdr) m_st = 2;
                endcase
            end
            m_park = pk;
            m_en = (m_st == 3);
            sp[1] = sp[0]; sp[0] = supply_ok;
            pp[1] = pp[0]; pp[0] = pwr_down_n;
            lp[1] = lp[0]; lp[0] = pll_lock;
            rp[1] = rp[0]; rp[0] = ref_tick;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            n_cmp++;
            if (int'(seq_state) != m_st || out_en != m_en || out_park_hi != m_park) begin
                n_bad++;
                $display("FAIL %s model: actual st=%0d en=%0b park=%0b expected st=%0d en=%0b park=%0b",
                         tag, seq_state, out_en, out_park_hi, m_st, m_en, m_park);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s directed: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle_len(input string req);
        int n = 0;
        for (int i = 0; i < 20 && seq_state != 2'd1; i++) @(negedge clk);
        while (seq_state == 2'd1 && n < 10000) begin
            @(negedge clk);
            n++;
        end
        chk(req, n, SC);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1: reset values
        chk("R1", seq_state, 0); chk("R1", out_en, 0); chk("R1", out_park_hi, 0);
        // R2: leave power off three edges after supply rises
        tag = "R2"; supply_ok = 1'b1;
        cyc(2); chk("R2", seq_state, 0);
        cyc(1); chk("R2", seq_state, 1);
        // R3: settling length
        tag = "R3";
        begin
            int n = 1;
            while (seq_state == 2'd1 && n < 10000) begin @(negedge clk); n++; end
            chk("R3", n - 1, SC);
        end
        chk("R3", seq_state, 2);
        // R5 / R6: clock starts, power-down still asserted
        tag = "R5"; pll_lock = 1'b1; ref_run = 1'b1;
        cyc(80); chk("R6", seq_state, 2); chk("R6", out_en, 0);
        // R6 / R7: release power-down
        tag = "R6"; pwr_down_n = 1'b1;
        cyc(2); chk("R6", seq_state, 2);
        cyc(2); chk("R6", seq_state, 3); chk("R7", out_en, 1);
        // R8: power-down and clock loss from run
        tag = "R8"; pwr_down_n = 1'b0;
        cyc(4); chk("R8", seq_state, 2); chk("R8", out_en, 0);
        pwr_down_n = 1'b1; cyc(4); chk("R8", seq_state, 3);
        ref_run = 1'b0; cyc(TO + 10); chk("R8", seq_state, 2); chk("R8", out_en, 0);
        // R10: park-high delay after release
        tag = "R10"; pwr_down_n = 1'b0; cfg_park_hi = 1'b1; cyc(5);
        chk("R10", out_park_hi, 0);
        pwr_down_n = 1'b1;
        cyc(PD + 2); chk("R10", out_park_hi, 0);
        cyc(1); chk("R10", out_park_hi, 1);
        // R9: no reference clock, stays waiting
        tag = "R9"; cyc(400); chk("R9", seq_state, 2); chk("R9", out_en, 0);
        cfg_park_hi = 1'b0;
        // R5: edges too sparse never validate
        tag = "R5"; ref_half = 12; ref_run = 1'b1;
        cyc(300); chk("R5", seq_state, 2);
        // R6: valid clock but no lock
        tag = "R6"; ref_half = 3; pll_lock = 1'b0;
        cyc(60); chk("R6", seq_state, 2);
        pll_lock = 1'b1; cyc(4); chk("R6", seq_state, 3);
        // R4: supply loss, then interrupted settle restarts in full
        tag = "R4"; supply_ok = 1'b0;
        cyc(3); chk("R4", seq_state, 0); chk("R4", out_en, 0);
        supply_ok = 1'b1; cyc(50); chk("R4", seq_state, 1);
        supply_ok = 1'b0; cyc(3); chk("R4", seq_state, 0);
        supply_ok = 1'b1; settle_len("R4");
        cyc(4); chk("R6", seq_state, 3);
        cyc(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule